// File: doc/BRIEF.md
# Buffered PWM Compare Timer Channel

This block is one timer channel that generates a pulse-width-modulated output. A 16-bit up-counter runs on every clock and wraps to zero when it equals compare register A, so compare A sets the period. Compare register B sets the duty point. An optional third compare register E serves as an extra match point; it is present when the parameter `HAS_E` is set. Each compare register can be paired with a buffer register (C feeds A, D feeds B, F feeds E). Software writes new values into the buffers while the channel runs, and hardware copies a buffer into its compare register at a chosen moment. A period or duty change therefore never lands in the middle of a period.

The moment of each copy is set per pair by a bit in an 8-bit transfer-timing register. The copy happens either when the counter matches that pair's own compare register, or when the counter clears. The counter-clear choice only applies while the channel is in PWM mode. Outside PWM mode a set bit is ignored, and the copy stays on the pair's own match. Buffering is enabled per pair in a mode register. With buffering off, a compare write takes effect at once and no copies happen.

Software reaches every register through a simple bus. The bus has a synchronous write strobe, a 4-bit address and 16-bit data, plus a combinational read port.

The PWM output comes from a three-state machine. `PWM_IDLE` drives the output low and is where the machine sits whenever PWM mode is off. `PWM_HIGH` drives the output high. `PWM_LOW` drives it low. The transitions are:
- `IDLE_TO_HIGH` happens on a counter clear while in PWM mode.
- `HIGH_TO_LOW` happens on a compare-B match without a clear.
- `LOW_TO_HIGH` happens on a counter clear.
- `ANY_TO_IDLE` happens when PWM mode is off.
- `HOLD` applies otherwise.

Top module: `pwm_buf_timer`

## Requirements
- R1: While reset is held, every readable register reads 0, and `pwm_out`, `flag_a`, `flag_b` and `flag_e` are 0.
- R2: The counter (address 0) increases by 1 each clock. In a cycle where it equals compare A (address 1), its next value is 0. A bus write to address 0 loads the written value instead, and the write takes priority over both the increment and the clear.
- R3: The transfer-timing register (address 9) stores bit 0 (buffer C into compare A), bit 1 (buffer D into compare B) and bit 2 (buffer F into compare E). All higher bits read 0 and ignore writes. Without the E pair, bit 2 also reads 0.
- R4: The mode register (address 8) stores the following bits, and all higher bits read 0:
  - bit 0: PWM mode.
  - bit 1: buffering for the A pair.
  - bit 2: buffering for the B pair.
  - bit 3: buffering for the E pair (reads 0 without that pair).
- R5: For a buffered pair whose timing bit is 0, the compare register takes the buffer value at the clock edge that ends a cycle in which the counter equals that compare register. The registers are:
  - compare A at address 1 with buffer C at address 3;
  - compare B at address 2 with buffer D at address 4;
  - compare E at address 5 with buffer F at address 6.
- R6: In PWM mode with the pair's timing bit at 1, the copy happens at the edge ending a counter-clear cycle, and not on the pair's own match.
- R7: Outside PWM mode, a timing bit of 1 has no effect: the copy still happens on the pair's own match.
- R8: With a pair's buffering off, a bus write to its compare register is visible in the next cycle and no buffer copy ever happens.
- R9: If a copy and a bus write to the same compare register fall in one cycle, the copied buffer value wins. A copied value takes part in matching only from the following cycle.
- R10: In PWM mode, `pwm_out` goes high in the cycle after a counter clear. It goes low in the cycle after a compare-B match that is not also a clear. Outside PWM mode it is low from the cycle after the mode bit drops.
- R11: `flag_a`, `flag_b` and `flag_e` are high for exactly the cycles that follow a cycle in which the counter equals compare A, B or E respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pwm_out | output | 1 | PWM output |
| flag_a | output | 1 | Compare-A match pulse |
| flag_b | output | 1 | Compare-B match pulse |
| flag_e | output | 1 | Compare-E match pulse (0 without the E pair) |

## Verification
Directed sequences cover each copy timing in turn:
- PWM mode with the B timing bit set, which separates a copy on clear from a copy on the pair's own match.
- The same bit with PWM mode off, which shows the bit is ignored.
- Buffering off, which separates an immediate write from a deferred copy.
- A bus write landing in the very cycle of a copy, which shows which source wins.

Duty settings below, above and at the period separate the clear-first priority of the output machine from plain match behaviour. A long constrained-random run then mixes period, duty, buffer, mode and timing writes with counter loads. Each cycle it compares the output, the flags and one randomly addressed register against a cycle model built from the requirements. This exposes ordering mistakes that only appear when writes, matches and clears coincide.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int ADDR_W    = 4;
    localparam int MAX_PAIRS = 3;

    localparam int PAIR_A = 0;
    localparam int PAIR_B = 1;
    localparam int PAIR_E = 2;

    localparam logic [ADDR_W-1:0] ADR_CNT    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_CMP_A  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_CMP_B  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_BUF_A  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_BUF_B  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_CMP_E  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_BUF_E  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_TIMING = 4'd9;

    typedef enum logic [1:0] {
        PWM_IDLE = 2'd0,
        PWM_HIGH = 2'd1,
        PWM_LOW  = 2'd2
    } pwm_state_e;

    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
        case (idx)
            PAIR_A:  return ADR_CMP_A;
            PAIR_B:  return ADR_CMP_B;
            default: return ADR_CMP_E;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] buf_addr(input int idx);
        case (idx)
            PAIR_A:  return ADR_BUF_A;
            PAIR_B:  return ADR_BUF_B;
            default: return ADR_BUF_E;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         clr
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign clr = (cnt == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wdata;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    AST_CLEAR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (cnt == '0)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en) |=> (cnt == $past(cnt) + ONE)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wdata))); // R2

endmodule

// File: rtl/pwmt_pair.sv
module pwmt_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         clr,
    input  logic         pwm_mode,
    input  logic         buf_en,
    input  logic         sel_clr,
    input  logic         wr_cmp,
    input  logic         wr_buf,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cmp,
    output logic [W-1:0] bufv,
    output logic         match
);

    logic trig;
    logic xfer;

    assign match = (cnt == cmp);
    assign trig  = (pwm_mode && sel_clr) ? clr : match;
    assign xfer  = buf_en && trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (xfer) begin
            cmp <= bufv;
        end else if (wr_cmp) begin
            cmp <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bufv <= '0;
        end else if (wr_buf) begin
            bufv <= wdata;
        end
    end

    AST_COPY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (cmp == $past(bufv))); // R5
    AST_CLEAR_ONLY_IN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !match) |-> (pwm_mode && sel_clr && clr)); // R6
    AST_SEL_IGNORED_OFF_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && buf_en && match && !wr_cmp) |=> (cmp == $past(bufv))); // R7
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && wr_cmp) |=> (cmp == $past(wdata))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && !wr_cmp) |=> $stable(cmp)); // R8

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int W     = 16,
    parameter bit HAS_E = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [W-1:0]                  bus_wdata,
    input  logic [W-1:0]                  cnt,
    input  logic [MAX_PAIRS-1:0][W-1:0]   cmp,
    input  logic [MAX_PAIRS-1:0][W-1:0]   bufv,
    output logic                          wr_cnt,
    output logic [MAX_PAIRS-1:0]          wr_cmp,
    output logic [MAX_PAIRS-1:0]          wr_buf,
    output logic                          pwm_mode,
    output logic [MAX_PAIRS-1:0]          buf_en,
    output logic [MAX_PAIRS-1:0]          sel_clr,
    output logic [W-1:0]                  bus_rdata
);

    localparam logic [MAX_PAIRS-1:0] PAIR_MASK = HAS_E ? 3'b111 : 3'b011;
    localparam int MODE_W = MAX_PAIRS + 1;

    logic                 pwm_q;
    logic [MAX_PAIRS-1:0] buf_en_q;
    logic [MAX_PAIRS-1:0] sel_q;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[W-1:MODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q    <= 1'b0;
            buf_en_q <= '0;
            sel_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_MODE) begin
                pwm_q    <= bus_wdata[0];
                buf_en_q <= bus_wdata[MODE_W-1:1] & PAIR_MASK;
            end
            if (bus_addr == ADR_TIMING) begin
                sel_q <= bus_wdata[MAX_PAIRS-1:0] & PAIR_MASK;
            end
        end
    end

    assign pwm_mode = pwm_q;
    assign buf_en   = buf_en_q;
    assign sel_clr  = sel_q;
    assign wr_cnt   = bus_wr && (bus_addr == ADR_CNT);

    always_comb begin
        for (int i = 0; i < MAX_PAIRS; i++) begin
            wr_cmp[i] = bus_wr && (bus_addr == cmp_addr(i));
            wr_buf[i] = bus_wr && (bus_addr == buf_addr(i));
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CNT:    bus_rdata = cnt;
            ADR_CMP_A:  bus_rdata = cmp[PAIR_A];
            ADR_CMP_B:  bus_rdata = cmp[PAIR_B];
            ADR_BUF_A:  bus_rdata = bufv[PAIR_A];
            ADR_BUF_B:  bus_rdata = bufv[PAIR_B];
            ADR_CMP_E:  bus_rdata = cmp[PAIR_E];
            ADR_BUF_E:  bus_rdata = bufv[PAIR_E];
            ADR_MODE:   bus_rdata[MODE_W-1:0] = {buf_en_q, pwm_q};
            ADR_TIMING: bus_rdata[MAX_PAIRS-1:0] = sel_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_TIMING_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_TIMING) |-> (bus_rdata[W-1:MAX_PAIRS] == '0)); // R3
    AST_MODE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_MODE) |-> (bus_rdata[W-1:MODE_W] == '0)); // R4
    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MODE) |=> (pwm_mode == $past(bus_wdata[0]))); // R4

endmodule

// File: rtl/pwmt_outfsm.sv
module pwmt_outfsm
    import pwmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_mode,
    input  logic clr,
    input  logic match_b,
    output logic pwm_out
);

    pwm_state_e state_q;
    pwm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_IDLE: begin
                if (pwm_mode && clr) state_d = PWM_HIGH;
            end
            PWM_HIGH: begin
                if (!pwm_mode)    state_d = PWM_IDLE;
                else if (clr)     state_d = PWM_HIGH;
                else if (match_b) state_d = PWM_LOW;
            end
            PWM_LOW: begin
                if (!pwm_mode) state_d = PWM_IDLE;
                else if (clr)  state_d = PWM_HIGH;
            end
            default: state_d = PWM_IDLE;
        endcase
    end

    always_comb begin
        pwm_out = (state_q == PWM_HIGH);
    end

    AST_HIGH_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && clr) |=> pwm_out); // R10
    AST_LOW_AFTER_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && match_b && !clr) |=> !pwm_out); // R10
    AST_LOW_OFF_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode |=> !pwm_out); // R10

endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter bit HAS_E = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             pwm_out,
    output logic             flag_a,
    output logic             flag_b,
    output logic             flag_e
);

    localparam int NPAIR = HAS_E ? 3 : 2;

    logic [CNT_W-1:0]                  cnt;
    logic                              clr;
    logic                              wr_cnt;
    logic [MAX_PAIRS-1:0]              wr_cmp;
    logic [MAX_PAIRS-1:0]              wr_buf;
    logic                              pwm_mode;
    logic [MAX_PAIRS-1:0]              buf_en;
    logic [MAX_PAIRS-1:0]              sel_clr;
    logic [MAX_PAIRS-1:0][CNT_W-1:0]   cmp;
    logic [MAX_PAIRS-1:0][CNT_W-1:0]   bufv;
    logic [MAX_PAIRS-1:0]              match;
    logic [MAX_PAIRS-1:0]              flag_q;

    pwmt_regs #(.W(CNT_W), .HAS_E(HAS_E)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .cmp       (cmp),
        .bufv      (bufv),
        .wr_cnt    (wr_cnt),
        .wr_cmp    (wr_cmp),
        .wr_buf    (wr_buf),
        .pwm_mode  (pwm_mode),
        .buf_en    (buf_en),
        .sel_clr   (sel_clr),
        .bus_rdata (bus_rdata)
    );

    pwmt_counter #(.W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_cnt),
        .wdata  (bus_wdata),
        .period (cmp[PAIR_A]),
        .cnt    (cnt),
        .clr    (clr)
    );

    for (genvar i = 0; i < MAX_PAIRS; i++) begin : g_pair
        if (i < NPAIR) begin : g_on
            pwmt_pair #(.W(CNT_W)) u_pair (
                .clk      (clk),
                .rst_n    (rst_n),
                .cnt      (cnt),
                .clr      (clr),
                .pwm_mode (pwm_mode),
                .buf_en   (buf_en[i]),
                .sel_clr  (sel_clr[i]),
                .wr_cmp   (wr_cmp[i]),
                .wr_buf   (wr_buf[i]),
                .wdata    (bus_wdata),
                .cmp      (cmp[i]),
                .bufv     (bufv[i]),
                .match    (match[i])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q[i] <= 1'b0;
                end else begin
                    flag_q[i] <= match[i];
                end
            end
        end else begin : g_off
            assign cmp[i]    = '0;
            assign bufv[i]   = '0;
            assign match[i]  = 1'b0;
            assign flag_q[i] = 1'b0;
        end
    end

    pwmt_outfsm u_outfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_mode (pwm_mode),
        .clr      (clr),
        .match_b  (match[PAIR_B]),
        .pwm_out  (pwm_out)
    );

    assign flag_a = flag_q[PAIR_A];
    assign flag_b = flag_q[PAIR_B];
    assign flag_e = flag_q[PAIR_E];

    AST_FLAG_FOLLOWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match[PAIR_B] |=> flag_b); // R11
    AST_FLAG_A_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> flag_a); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!pwm_out && !flag_a && !flag_b && !flag_e)); // R1

endmodule

// File: tb/test_pwm_buf_timer.sv
module test_pwm_buf_timer;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        pwm_out, flag_a, flag_b, flag_e;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_buf_timer i_pwm_buf_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
        .flag_a(flag_a), .flag_b(flag_b), .flag_e(flag_e)
    );

    // ---------------- reference model from the requirements ----------------
    logic [15:0] m_cnt;
    logic [15:0] m_cmp [3];
    logic [15:0] m_buf [3];
    logic [3:0]  m_mode;
    logic [2:0]  m_sel;
    logic        m_pwm;
    logic [2:0]  m_flag;
    logic [15:0] n_cnt;
    logic [15:0] n_cmp [3];
    logic [2:0]  hit;
    logic        m_clr, m_trig;

    function automatic logic [3:0] cmp_ad(input int i);
        return (i == 0) ? 4'd1 : (i == 1) ? 4'd2 : 4'd5;
    endfunction

    function automatic logic [3:0] buf_ad(input int i);
        return (i == 0) ? 4'd3 : (i == 1) ? 4'd4 : 4'd6;
    endfunction

    function automatic logic [15:0] mread(input logic [3:0] a);
        case (a)
            4'd0: return m_cnt;
            4'd1: return m_cmp[0];
            4'd2: return m_cmp[1];
            4'd3: return m_buf[0];
            4'd4: return m_buf[1];
            4'd5: return m_cmp[2];
            4'd6: return m_buf[2];
            4'd8: return {12'd0, m_mode};
            4'd9: return {13'd0, m_sel};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_sel = 0; m_pwm = 0; m_flag = 0;
            for (int i = 0; i < 3; i++) begin m_cmp[i] = 0; m_buf[i] = 0; end
        end else begin
            m_clr = (m_cnt == m_cmp[0]);
            for (int i = 0; i < 3; i++) hit[i] = (m_cnt == m_cmp[i]);
            n_cnt = (bus_wr && bus_addr == 4'd0) ? bus_wdata : (m_clr ? 16'd0 : m_cnt + 16'd1);
            for (int i = 0; i < 3; i++) begin
                m_trig = m_mode[i+1] && ((m_mode[0] && m_sel[i]) ? m_clr : hit[i]);
                n_cmp[i] = m_trig ? m_buf[i]
                         : (bus_wr && bus_addr == cmp_ad(i)) ? bus_wdata : m_cmp[i];
            end
            for (int i = 0; i < 3; i++)
                if (bus_wr && bus_addr == buf_ad(i)) m_buf[i] = bus_wdata;
            m_pwm = m_mode[0] ? (m_clr ? 1'b1 : (hit[1] ? 1'b0 : m_pwm)) : 1'b0;
            m_flag = hit;
            if (bus_wr && bus_addr == 4'd8) m_mode = bus_wdata[3:0];
            if (bus_wr && bus_addr == 4'd9) m_sel = bus_wdata[2:0];
            m_cnt = n_cnt;
            for (int i = 0; i < 3; i++) m_cmp[i] = n_cmp[i];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(req, $sformatf("reg %0d", a), bus_rdata, exp);
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        bus_addr = 4'd0;
        #1;
        while (bus_rdata !== v) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 10; a++) rd_chk("R1", a[3:0], 16'd0);
        chk("R1", "outputs", {12'd0, pwm_out, flag_e, flag_b, flag_a}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: PWM mode, B select 1 -> copy on clear only
        wr(4'd1, 16'd9); wr(4'd8, 16'h0005); wr(4'd9, 16'h0002);
        wr(4'd2, 16'd3); wr(4'd4, 16'd5); wr(4'd0, 16'd0);
        wait_cnt(16'd5); rd_chk("R6", 4'd2, 16'd3);
        wait_cnt(16'd1); rd_chk("R6", 4'd2, 16'd5);
        chk("R10", "pwm after clear", {15'd0, pwm_out}, 16'd1);
        wait_cnt(16'd7);
        chk("R10", "pwm after duty", {15'd0, pwm_out}, 16'd0);

        // R7: select 1 ignored outside PWM mode
        wr(4'd8, 16'h0004); wr(4'd4, 16'd7);
        wait_cnt(16'd2); wait_cnt(16'd7);
        rd_chk("R7", 4'd2, 16'd7);
        chk("R10", "pwm off mode", {15'd0, pwm_out}, 16'd0);

        // R8: unbuffered writes immediate, no copies
        wr(4'd8, 16'h0000); wr(4'd2, 16'd2);
        rd_chk("R8", 4'd2, 16'd2);
        wr(4'd4, 16'd8);
        wait_cnt(16'd9); wait_cnt(16'd3);
        rd_chk("R8", 4'd2, 16'd2);

        // R9: copy beats same-cycle bus write
        wr(4'd4, 16'd6);
        wait_cnt(16'd5); wr(4'd8, 16'h0004);
        wait_cnt(16'd2); rd_chk("R9", 4'd2, 16'd2);
        wr(4'd2, 16'h0055);
        rd_chk("R9", 4'd2, 16'd6);

        // R10 / R11: duty beyond period, then normal duty and flags
        wr(4'd8, 16'h0001); wr(4'd2, 16'd20);
        wait_cnt(16'd1); wait_cnt(16'd5);
        chk("R10", "duty above period", {15'd0, pwm_out}, 16'd1);
        wr(4'd2, 16'd3);
        wait_cnt(16'd1); wait_cnt(16'd4);
        chk("R11", "flag_b after match", {15'd0, flag_b}, 16'd1);
        chk("R10", "pwm low after match", {15'd0, pwm_out}, 16'd0);
        wait_cnt(16'd5);
        chk("R11", "flag_b one cycle", {15'd0, flag_b}, 16'd0);
        wait_cnt(16'd0);
        chk("R11", "flag_a after period", {15'd0, flag_a}, 16'd1);

        // R2: counter load, step, wrap
        wr(4'd0, 16'd3); rd_chk("R2", 4'd0, 16'd3);
        @(negedge clk); rd_chk("R2", 4'd0, 16'd4);
        wait_cnt(16'd9); @(negedge clk); rd_chk("R2", 4'd0, 16'd0);

        // R5: select 0 -> copy on own match
        wr(4'd9, 16'h0000); wr(4'd8, 16'h0005); wr(4'd4, 16'd8);
        wait_cnt(16'd1); wait_cnt(16'd4);
        rd_chk("R5", 4'd2, 16'd8);

        // R3 / R4: reserved bits
        wr(4'd9, 16'hFFFF); rd_chk("R3", 4'd9, 16'h0007);
        wr(4'd8, 16'hFFF0); rd_chk("R4", 4'd8, 16'h0000);
        wr(4'd8, 16'h00FF); rd_chk("R4", 4'd8, 16'h000F);

        // constrained random against the model
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < RAND_CYCLES; n++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            chk("R10", "pwm", {15'd0, pwm_out}, {15'd0, m_pwm});
            chk("R11", "flags", {13'd0, flag_e, flag_b, flag_a}, {13'd0, m_flag});
            begin
                logic [3:0] ra;
                ra = 4'($urandom % 10);
                bus_addr = ra;
                #1;
                chk((ra == 0) ? "R2" : (ra == 8) ? "R4" : (ra == 9) ? "R3" : "R5",
                    $sformatf("random read %0d", ra), bus_rdata, mread(ra));
            end
            if ($urandom % 4 == 0) begin
                logic [3:0] wa;
                wa = 4'($urandom % 10);
                bus_wr = 1'b1;
                bus_addr = wa;
                if (wa == 4'd8 || wa == 4'd9)      bus_wdata = 16'($urandom);
                else if (wa == 4'd1 || wa == 4'd3) bus_wdata = 16'(4 + $urandom % 24);
                else                               bus_wdata = 16'($urandom % 28);
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule